// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block decides when a system leaves reset. It watches a supply-good flag, produced by an analog comparator outside the block and already synchronized to the block clock. It asserts a system reset whenever that flag reports the supply below its trip level. When the supply recovers, the block keeps reset asserted for a fixed time-out before releasing it. The time-out is counted in ticks of a slow oscillator that arrives as a one-cycle clock enable. With the default setting of 750 ticks at 5 kHz, the time-out is 150 ms.

The block has two reset pins, one active high and one active low. Both are open drain, and the block drives each one only through an enable. The same pins are also sampled back as inputs. This lets an external reset pulse of any length be stretched into a full timed reset.

A rising edge on the active-high pin starts a new full time-out. So does a falling edge on the active-low pin. Pin activity that the block causes itself is not treated as a trigger: this covers the pins following the block's own drive and the pins returning to idle at release. An asynchronous power-on reset forces the asserted state and clears the tick counter.

Top module: `supply_reset_seq`

## Requirements
- R1: While the asynchronous reset input is low, both drive enables read 1, whatever the supply flag says.
- R2: When the supply flag is 0, both drive enables read 1 in the same cycle, before any clock edge.
- R3: After the supply flag returns to 1, reset stays asserted until HOLD_TICKS (default 750) tick enables have been counted. The drive enables fall one clock after the edge that carries the last counted tick.
- R4: Ticks that arrive while the supply flag is 0 are not counted. A supply drop during a time-out discards the partial count, and a full HOLD_TICKS time-out follows the recovery.
- R5: While reset is released, a 0-to-1 change on the active-high pin input starts a full time-out. Both enables read 1 one clock later.
- R6: While reset is released, a 1-to-0 change on the active-low pin input starts a full time-out. Both enables read 1 one clock later.
- R7: The block never retriggers itself. With no external pin activity after a release, reset stays released. A pin held active by an outside source through the release does not retrigger.
- R8: Both drive enables always carry the same value. A 1 on the high-side enable drives the active-high pin high. A 1 on the low-side enable pulls the active-low pin low.
- R9: While reset is released, a 1-to-0 change on the active-high pin and a 0-to-1 change on the active-low pin have no effect.
- R10: A tick that coincides with the clock edge on which a time-out starts is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstAsyncN | input | 1 | Asynchronous power-on reset, active low |
| tickEn | input | 1 | One-cycle enable from the slow oscillator |
| supplyOk | input | 1 | Synchronized comparator flag, 1 when the supply is above trip |
| rstHiPin | input | 1 | Sampled level of the active-high reset pin |
| rstLoPin | input | 1 | Sampled level of the active-low reset pin |
| rstHiDrive | output | 1 | Enable that drives the active-high pin high |
| rstLoDrive | output | 1 | Enable that pulls the active-low pin low |

## Verification
A supply drop (R2) is due in the same cycle, so the bench checks it 1 ns after changing the flag and before the next edge. The start of a time-out, whether from a pin edge or a supply recovery, is due one clock after the edge that sees the cause. The release is due one clock after the edge carrying the HOLD_TICKS-th counted tick.

The bench changes inputs on the falling clock edge and samples one half-period later. At that point every registered output has settled. It sweeps every tick position in the time-out, both with back-to-back ticks and with idle cycles between ticks. At each position it compares both enables with an arithmetic expectation: asserted before the last tick, released after it.

// File: rtl/supply_reset_pkg.sv
package supply_reset_pkg;

  typedef enum logic [1:0] {
    ST_LOW  = 2'd0,
    ST_HOLD = 2'd1,
    ST_RUN  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic edgeArm;
  } ctrlStrobe_t;

  typedef struct packed {
    logic cntLast;
    logic trigger;
  } dpFlag_t;

endpackage

// File: rtl/supply_reset_edge.sv
module supply_reset_edge #(
  parameter bit ACTIVE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rstAsyncN,
  input  logic pinIn,
  input  logic arm,
  output logic hit
);

  logic prevQ;

  // The previous sample resets to the active level, so a pin that is
  // already active when sampling starts does not count as an edge.
  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN) prevQ <= ACTIVE_LEVEL;
    else            prevQ <= pinIn;
  end

  assign hit = arm && (pinIn == ACTIVE_LEVEL) && (prevQ != ACTIVE_LEVEL);

endmodule

// File: rtl/supply_reset_dp.sv
module supply_reset_dp
  import supply_reset_pkg::*;
#(
  parameter int HOLD_TICKS = 750,
  parameter int NUM_PINS   = 2
) (
  input  logic                clk,
  input  logic                rstAsyncN,
  input  logic [NUM_PINS-1:0] pinsIn,
  input  ctrlStrobe_t         strobe,
  output dpFlag_t             flag
);

  localparam int CNT_W = $clog2(HOLD_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_TICKS - 1);

  logic [CNT_W-1:0]    tickCnt;
  logic [NUM_PINS-1:0] pinHit;

  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN)          tickCnt <= '0;
    else if (strobe.cntClear) tickCnt <= '0;
    else if (strobe.cntInc)   tickCnt <= tickCnt + 1'b1;
  end

  // Pin 0 is active high and every other pin is active low.
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    supply_reset_edge #(
      .ACTIVE_LEVEL((g == 0) ? 1'b1 : 1'b0)
    ) u_edge (
      .clk       (clk),
      .rstAsyncN (rstAsyncN),
      .pinIn     (pinsIn[g]),
      .arm       (strobe.edgeArm),
      .hit       (pinHit[g])
    );
  end

  assign flag.cntLast = (tickCnt == CNT_LAST);
  assign flag.trigger = |pinHit;

endmodule

// File: rtl/supply_reset_ctrl.sv
module supply_reset_ctrl
  import supply_reset_pkg::*;
(
  input  logic        clk,
  input  logic        rstAsyncN,
  input  logic        tickEn,
  input  logic        supplyOk,
  input  dpFlag_t     flag,
  output ctrlStrobe_t strobe,
  output logic        rstActive
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    if (!supplyOk) begin
      stateNext = ST_LOW;
    end else begin
      unique case (state)
        ST_LOW:  stateNext = ST_HOLD;
        ST_HOLD: if (tickEn && flag.cntLast) stateNext = ST_RUN;
        ST_RUN:  if (flag.trigger) stateNext = ST_HOLD;
        default: stateNext = ST_LOW;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN) state <= ST_LOW;
    else            state <= stateNext;
  end

  always_comb begin
    strobe.cntClear = (state != ST_HOLD) || !supplyOk;
    strobe.cntInc   = (state == ST_HOLD) && supplyOk && tickEn;
    strobe.edgeArm  = (state == ST_RUN) && supplyOk;
  end

  // A bad supply asserts the outputs combinationally, with no clock delay.
  assign rstActive = (state != ST_RUN) || !supplyOk || !rstAsyncN;

endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
  import supply_reset_pkg::*;
#(
  parameter int HOLD_TICKS = 750
) (
  input  logic clk,
  input  logic rstAsyncN,
  input  logic tickEn,
  input  logic supplyOk,
  input  logic rstHiPin,
  input  logic rstLoPin,
  output logic rstHiDrive,
  output logic rstLoDrive
);

  ctrlStrobe_t strobe;
  dpFlag_t     flag;
  logic        rstActive;

  supply_reset_ctrl u_ctrl (
    .clk       (clk),
    .rstAsyncN (rstAsyncN),
    .tickEn    (tickEn),
    .supplyOk  (supplyOk),
    .flag      (flag),
    .strobe    (strobe),
    .rstActive (rstActive)
  );

  supply_reset_dp #(
    .HOLD_TICKS (HOLD_TICKS),
    .NUM_PINS   (2)
  ) u_dp (
    .clk       (clk),
    .rstAsyncN (rstAsyncN),
    .pinsIn    ({rstLoPin, rstHiPin}),
    .strobe    (strobe),
    .flag      (flag)
  );

  assign rstHiDrive = rstActive;
  assign rstLoDrive = rstActive;

endmodule

// File: rtl/supply_reset_chk.sv
module supply_reset_chk #(
  parameter int HOLD_TICKS = 750
) (
  input logic clk,
  input logic rstAsyncN,
  input logic tickEn,
  input logic supplyOk,
  input logic rstHiPin,
  input logic rstLoPin,
  input logic rstHiDrive,
  input logic rstLoDrive
);

  localparam int CHK_W = $clog2(HOLD_TICKS + 2);

  logic [CHK_W-1:0] heldTicks;
  logic             supplyPrev;

  // Counts ticks seen at the ports while reset is held with a good supply.
  // A tick on the first cycle after supply recovery is excluded.
  always_ff @(posedge clk or negedge rstAsyncN) begin
    if (!rstAsyncN) begin
      heldTicks  <= '0;
      supplyPrev <= 1'b0;
    end else begin
      supplyPrev <= supplyOk;
      if (!(rstHiDrive && supplyOk))
        heldTicks <= '0;
      else if (tickEn && supplyPrev && heldTicks <= CHK_W'(HOLD_TICKS))
        heldTicks <= heldTicks + 1'b1;
    end
  end

  p_low_supply_r2: assert property (@(posedge clk) disable iff (!rstAsyncN)
    !supplyOk |-> (rstHiDrive && rstLoDrive));

  p_release_count_r3: assert property (@(posedge clk) disable iff (!rstAsyncN)
    $fell(rstHiDrive) |-> (heldTicks == CHK_W'(HOLD_TICKS)));

  p_no_overrun_r3: assert property (@(posedge clk) disable iff (!rstAsyncN)
    heldTicks <= CHK_W'(HOLD_TICKS));

  p_release_on_tick_r3: assert property (@(posedge clk) disable iff (!rstAsyncN)
    $fell(rstLoDrive) |-> $past(tickEn));

  p_hi_edge_r5: assert property (@(posedge clk) disable iff (!rstAsyncN)
    (!rstHiDrive && $rose(rstHiPin)) |=> rstHiDrive);

  p_lo_edge_r6: assert property (@(posedge clk) disable iff (!rstAsyncN)
    (!rstLoDrive && $fell(rstLoPin)) |=> rstLoDrive);

  p_drives_agree_r8: assert property (@(posedge clk) disable iff (!rstAsyncN)
    $rose(rstHiDrive) |-> $rose(rstLoDrive));

endmodule

bind supply_reset_seq supply_reset_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
  .clk        (clk),
  .rstAsyncN  (rstAsyncN),
  .tickEn     (tickEn),
  .supplyOk   (supplyOk),
  .rstHiPin   (rstHiPin),
  .rstLoPin   (rstLoPin),
  .rstHiDrive (rstHiDrive),
  .rstLoDrive (rstLoDrive)
);

// File: tb/supply_reset_seq_test.sv
`timescale 1ns/1ps
module supply_reset_seq_test;

  localparam int HOLD = 750;

  logic clk = 1'b0;
  logic rstAsyncN = 1'b0;
  logic tickEn = 1'b0;
  logic supplyOk = 1'b0;
  logic extHi = 1'b0;
  logic extLo = 1'b0;
  logic rstHiPin, rstLoPin, rstHiDrive, rstLoDrive;
  int   checks = 0;
  int   errors = 0;

  always #4 clk = ~clk;

  // Open-drain pin models: the block or an outside source may pull each pin
  // to its active level.
  assign rstHiPin = rstHiDrive | extHi;
  assign rstLoPin = !(rstLoDrive | extLo);

  supply_reset_seq uut (
    .clk        (clk),
    .rstAsyncN  (rstAsyncN),
    .tickEn     (tickEn),
    .supplyOk   (supplyOk),
    .rstHiPin   (rstHiPin),
    .rstLoPin   (rstLoPin),
    .rstHiDrive (rstHiDrive),
    .rstLoDrive (rstLoDrive)
  );

  task automatic step(input logic t);
    tickEn = t;
    @(posedge clk);
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  // Both enables are compared, which also covers R8 on every check.
  task automatic expectRst(input logic exp, input string req);
    checks++;
    if (rstHiDrive !== exp || rstLoDrive !== exp) begin
      errors++;
      $display("FAIL %s: hiDrive=%b loDrive=%b expected %b", req, rstHiDrive, rstLoDrive, exp);
    end
  endtask

  task automatic quiet(input int n, input logic exp, input string req);
    for (int i = 0; i < n; i++) begin
      step(1'b1);
      expectRst(exp, req);
    end
  endtask

  // The first step is the edge that starts the time-out. Then HOLD ticks are
  // delivered with gap idle cycles before each, and release is due after the last.
  task automatic holdSweep(input logic entryTick, input int gap, input string req);
    step(entryTick);
    expectRst(1'b1, req);
    for (int i = 1; i <= HOLD; i++) begin
      for (int j = 0; j < gap; j++) begin
        step(1'b0);
        expectRst(1'b1, req);
      end
      step(1'b1);
      expectRst((i < HOLD) ? 1'b1 : 1'b0, req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: asserted during reset, even with a good supply.
    #3;
    expectRst(1'b1, "R1");
    supplyOk = 1'b1;
    #1;
    expectRst(1'b1, "R1");
    @(negedge clk);
    supplyOk = 1'b0;
    @(negedge clk);
    rstAsyncN = 1'b1;

    // R4: ticks with a low supply are ignored.
    quiet(20, 1'b1, "R4");

    // R3 and R10: recovery with a tick on the entry edge, back-to-back ticks.
    supplyOk = 1'b1;
    holdSweep(1'b1, 0, "R3 R10");
    quiet(8, 1'b0, "R7");

    // R5: rising external pulse on the active-high pin, sparse ticks.
    extHi = 1'b1;
    holdSweep(1'b0, 2, "R5");
    quiet(5, 1'b0, "R7");
    extHi = 1'b0;
    quiet(5, 1'b0, "R9");

    // R6: falling external pulse on the active-low pin, entry tick ignored.
    extLo = 1'b1;
    holdSweep(1'b1, 0, "R6 R10");
    quiet(5, 1'b0, "R7");
    extLo = 1'b0;
    quiet(5, 1'b0, "R9");

    // R2: immediate assertion on supply loss.
    supplyOk = 1'b0;
    #1;
    expectRst(1'b1, "R2");
    @(negedge clk);
    quiet(4, 1'b1, "R4");

    // R4: a drop partway through a time-out restarts the full count.
    supplyOk = 1'b1;
    step(1'b0);
    expectRst(1'b1, "R4");
    quiet(300, 1'b1, "R4");
    supplyOk = 1'b0;
    #1;
    expectRst(1'b1, "R2");
    @(negedge clk);
    step(1'b1);
    expectRst(1'b1, "R4");
    supplyOk = 1'b1;
    holdSweep(1'b0, 0, "R4");

    // R1: asynchronous reset while released.
    rstAsyncN = 1'b0;
    #1;
    expectRst(1'b1, "R1");
    @(negedge clk);
    quiet(3, 1'b1, "R1");
    rstAsyncN = 1'b1;
    holdSweep(1'b1, 0, "R1 R3");
    quiet(5, 1'b0, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule